// File: doc/BRIEF.md
# Hybrid Modular Redundancy Manager

This block sits behind a bank of identical processing modules and keeps a single trustworthy result. A fixed number of primary modules start out active. A further set of standby modules runs alongside them but is held out of the vote. Every cycle, the block forms a bitwise majority over the result buses of the currently active slots and presents it as the system result. A lone faulty module is therefore outvoted and causes no visible error.

Each active slot is also compared with the voted result. When a slot has disagreed with the vote for a configurable number of consecutive cycles, the block retires it. The slot leaves the voting set, and the lowest-numbered unused standby slot takes its place. When no standby is left, the failed slot is dropped and the active set shrinks. The vote stays combinational over the current active set, so masking stays in force on the very cycle a swap is decided.

The reconfiguration unit has two states. `RC_SPARES` means at least one standby remains, and `RC_BARE` means all standbys are used. Three transitions exist:
- `T_SWAP` retires a slot and activates a standby while standbys remain (`RC_SPARES` to `RC_SPARES`).
- `T_LAST_SWAP` uses the final standby (`RC_SPARES` to `RC_BARE`).
- `T_DROP` removes a failed slot with nothing to replace it (`RC_BARE` to `RC_BARE`).

Reset enters `RC_SPARES`, or `RC_BARE` when no standbys are configured.

Top module: `hnmr_manager`

## Requirements
- R1: After reset, the active mask holds only the primary slots (bits 0 to N-1 set, standby bits N to N+M-1 clear), and `fault_o`, `multi_fault_o` and `spares_exhausted_o` are low.
- R2: Each bit of `voted_o` is 1 exactly when more than half of the active slots carry a 1 in that bit. A tie, or an empty active set, gives 0. Inactive slots, whether standby or retired, have no influence.
- R3: A single disagreeing active slot never changes `voted_o`, including the cycle in which its retirement is decided and the cycle after.
- R4: A slot that disagrees for fewer than K consecutive cycles (default K=2) is not retired. Any agreeing cycle restarts its count.
- R5: On the clock edge that ends a slot's K-th consecutive disagreeing cycle, the slot's mask bit clears. In the same edge `fault_o` rises for exactly one cycle, and at most one slot is retired per edge.
- R6: Standbys are brought in in ascending index order (slot N first), each at most once. A primary slot or a retired slot never becomes active again.
- R7: Once every standby has been used, `spares_exhausted_o` is high and stays high until reset. A further failure then only clears the failed slot's bit.
- R8: If several slots reach the retirement decision in the same cycle, only the lowest-index one is retired. `multi_fault_o` pulses together with `fault_o`, and the others are retired on later edges if they still disagree.
- R9: The number of active slots never increases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_bus_i | input | (N+M)*W | Result buses of all slots; slot i occupies bits i*W to i*W+W-1, primaries in slots 0..N-1 |
| voted_o | output | W | Bitwise majority over the active slots |
| active_mask_o | output | N+M | One bit per slot, 1 when the slot takes part in the vote |
| fault_o | output | 1 | One-cycle pulse when a slot has been retired |
| multi_fault_o | output | 1 | One-cycle pulse when more than one slot reached the retirement decision together |
| spares_exhausted_o | output | 1 | High when no unused standby remains |

## Verification
The assertions watch every cycle for the following:
- at most one slot leaves per edge;
- the active count never grows;
- only standbys can join, one at a time;
- the exhausted flag is sticky;
- a multi-fault pulse comes only with a fault pulse;
- a fault pulse always comes with a changed mask;
- a unanimous column among active slots always passes to the vote;
- a retirement decision always follows a disagreement in the previous cycle.

Only the bench scenarios can show the rest. These cover the exact cycle on which a retirement lands, the order in which standbys are chosen, the tie rule with an even number of active slots, the filtering of short disagreement bursts, and the lowest-index choice when several slots fail at once. An exhaustive sweep over all triples of three-bit patterns exercises the majority function.

// File: rtl/hnmr_pkg.sv
package hnmr_pkg;

    // Reconfiguration unit states
    typedef enum logic [0:0] {
        RC_SPARES = 1'b0,   // at least one unused standby remains
        RC_BARE   = 1'b1    // every standby has been consumed
    } rc_state_e;

    // Transition taken on a retirement edge
    typedef enum logic [1:0] {
        T_NONE      = 2'd0,
        T_SWAP      = 2'd1,
        T_LAST_SWAP = 2'd2,
        T_DROP      = 2'd3
    } rc_trans_e;

endpackage

// File: rtl/hnmr_voter.sv
module hnmr_voter #(
    parameter int S = 5,
    parameter int W = 8
) (
    input  logic [S*W-1:0] slot_bus_i,
    input  logic [S-1:0]   active_i,
    output logic [W-1:0]   voted_o
);
    localparam int CW = $clog2(S + 1) + 1;

    logic [CW-1:0] n_active;

    always_comb begin
        n_active = '0;
        for (int i = 0; i < S; i++) begin
            n_active = n_active + {{(CW-1){1'b0}}, active_i[i]};
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [CW-1:0] ones;
        always_comb begin
            ones = '0;
            for (int i = 0; i < S; i++) begin
                ones = ones + {{(CW-1){1'b0}}, (active_i[i] & slot_bus_i[i*W + b])};
            end
        end
        // strict majority: 2*ones > active count
        assign voted_o[b] = ({ones[CW-2:0], 1'b0} > n_active);
    end

endmodule

// File: rtl/hnmr_disagree.sv
module hnmr_disagree #(
    parameter int S = 5,
    parameter int W = 8,
    parameter int K = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [S*W-1:0] slot_bus_i,
    input  logic [W-1:0]   voted_i,
    input  logic [S-1:0]   active_i,
    output logic [S-1:0]   decide_o
);
    localparam int CW = $clog2(K + 1);
    localparam logic [CW-1:0] LIMIT = CW'(K - 1);

    logic [S-1:0] mism;

    for (genvar i = 0; i < S; i++) begin : g_slot
        logic [CW-1:0] run_q;

        assign mism[i]     = active_i[i] && (slot_bus_i[i*W +: W] != voted_i);
        assign decide_o[i] = mism[i] && (run_q == LIMIT);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q <= '0;
            end else if (!mism[i]) begin
                run_q <= '0;              // any agreement restarts the count
            end else if (run_q != LIMIT) begin
                run_q <= run_q + 1'b1;
            end
        end

        if (K >= 2) begin : g_filt
            // R4: a decision needs a disagreement in the cycle before
            p_needs_history_r4: assert property (@(posedge clk) disable iff (!rst_n)
                decide_o[i] |-> $past(mism[i]));
        end
    end

endmodule

// File: rtl/hnmr_reconfig.sv
module hnmr_reconfig
    import hnmr_pkg::*;
#(
    parameter int N = 3,
    parameter int M = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N+M-1:0] decide_i,
    output logic [N+M-1:0] active_o,
    output logic           fault_o,
    output logic           multi_o,
    output logic           exhausted_o
);
    localparam int S  = N + M;
    localparam int IW = (S > 1) ? $clog2(S) : 1;
    localparam int PW = $clog2(M + 2);
    localparam logic [S-1:0] PRIMARY_MASK = S'((1 << N) - 1);
    localparam rc_state_e RESET_STATE = (M > 0) ? RC_SPARES : RC_BARE;

    rc_state_e    state_q, state_d;
    rc_trans_e    trans;
    logic [S-1:0] mask_q, mask_d;
    logic [PW-1:0] ptr_q, ptr_d;
    logic [IW-1:0] victim;
    logic          any_hit, multi_hit;
    logic          fault_q, multi_q;

    // lowest-index slot that reached its decision
    always_comb begin
        victim = '0;
        for (int i = S - 1; i >= 0; i--) begin
            if (decide_i[i]) victim = IW'(i);
        end
        any_hit   = |decide_i;
        multi_hit = ($countones(decide_i) > 1);
    end

    // next state, next mask, next standby pointer
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        ptr_d   = ptr_q;
        trans   = T_NONE;
        if (any_hit) begin
            mask_d[victim] = 1'b0;
            unique case (state_q)
                RC_SPARES: begin
                    for (int j = 0; j < M; j++) begin
                        if (int'(ptr_q) == j) mask_d[N + j] = 1'b1;
                    end
                    ptr_d = ptr_q + 1'b1;
                    if (int'(ptr_q) + 1 >= M) begin
                        state_d = RC_BARE;
                        trans   = T_LAST_SWAP;
                    end else begin
                        trans   = T_SWAP;
                    end
                end
                RC_BARE: begin
                    trans = T_DROP;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
            mask_q  <= PRIMARY_MASK;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            ptr_q   <= ptr_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            multi_q <= 1'b0;
        end else begin
            fault_q <= (trans != T_NONE);
            multi_q <= multi_hit;
        end
    end

    assign active_o    = mask_q;
    assign fault_o     = fault_q;
    assign multi_o     = multi_q;
    assign exhausted_o = (state_q == RC_BARE);

    // R6: a swap brings in exactly one new slot on the next edge
    p_swap_adds_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RC_SPARES && any_hit) |=> ($countones(mask_q & ~$past(mask_q)) == 1));

    // R7: a drop brings in nothing
    p_drop_adds_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RC_BARE && any_hit) |=> ((mask_q & ~$past(mask_q)) == '0));

endmodule

// File: rtl/hnmr_manager.sv
module hnmr_manager #(
    parameter int N = 3,
    parameter int M = 2,
    parameter int W = 8,
    parameter int K = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [(N+M)*W-1:0] slot_bus_i,
    output logic [W-1:0]       voted_o,
    output logic [N+M-1:0]     active_mask_o,
    output logic               fault_o,
    output logic               multi_fault_o,
    output logic               spares_exhausted_o
);
    localparam int S = N + M;
    localparam logic [S-1:0] PRIMARY_MASK = S'((1 << N) - 1);

    logic [S-1:0] active;
    logic [S-1:0] decide;
    logic [W-1:0] voted;

    hnmr_voter #(.S(S), .W(W)) u_voter (
        .slot_bus_i (slot_bus_i),
        .active_i   (active),
        .voted_o    (voted)
    );

    hnmr_disagree #(.S(S), .W(W), .K(K)) u_disagree (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_bus_i (slot_bus_i),
        .voted_i    (voted),
        .active_i   (active),
        .decide_o   (decide)
    );

    hnmr_reconfig #(.N(N), .M(M)) u_reconfig (
        .clk         (clk),
        .rst_n       (rst_n),
        .decide_i    (decide),
        .active_o    (active),
        .fault_o     (fault_o),
        .multi_o     (multi_fault_o),
        .exhausted_o (spares_exhausted_o)
    );

    assign voted_o       = voted;
    assign active_mask_o = active;

    // R5: at most one slot leaves per edge
    p_one_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(active) & ~active) <= 1);

    // R5: a fault pulse always accompanies a mask change
    p_fault_moves_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (active != $past(active)));

    // R9: the active count never grows
    p_no_regrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active) <= $countones($past(active)));

    // R6: primaries never rejoin
    p_no_primary_rejoin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((active & ~$past(active) & PRIMARY_MASK) == '0));

    // R7: exhaustion is sticky
    p_exhaust_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spares_exhausted_o |=> spares_exhausted_o);

    // R8: multi-fault only together with a fault
    p_multi_with_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        multi_fault_o |-> fault_o);

    // R3: a column on which all active slots agree is passed through
    for (genvar b = 0; b < W; b++) begin : g_col
        logic [S-1:0] col;
        for (genvar i = 0; i < S; i++) begin : g_pick
            assign col[i] = slot_bus_i[i*W + b];
        end
        p_unanimous_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((active != '0) && ((col & active) == active)) |-> voted[b]);
        p_unanimous_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((col & active) == '0) |-> !voted[b]);
    end

endmodule

// File: tb/hnmr_manager_tb.sv
module hnmr_manager_tb;
    localparam int N = 3;
    localparam int M = 2;
    localparam int W = 8;
    localparam int K = 2;
    localparam int S = N + M;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     slot [S];
    logic [S*W-1:0]   bus;
    logic [W-1:0]     voted;
    logic [S-1:0]     mask;
    logic             fault, multi, exh;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    always_comb begin
        for (int i = 0; i < S; i++) bus[i*W +: W] = slot[i];
    end

    hnmr_manager #(.N(N), .M(M), .W(W), .K(K)) u_dut (
        .clk                (clk),
        .rst_n              (rst_n),
        .slot_bus_i         (bus),
        .voted_o            (voted),
        .active_mask_o      (mask),
        .fault_o            (fault),
        .multi_fault_o      (multi),
        .spares_exhausted_o (exh)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // wait past an edge, then drive; checks follow 5 ns later
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic all_slots(input logic [W-1:0] v);
        for (int i = 0; i < S; i++) slot[i] = v;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
    endtask

    function automatic logic [W-1:0] maj3(input logic [W-1:0] a, b, c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        all_slots(8'h5A);
        do_reset();
        #5;
        // R1 reset state
        chk("R1 mask", 32'(mask), 32'b00111);
        chk("R1 fault", 32'(fault), 0);
        chk("R1 multi", 32'(multi), 0);
        chk("R1 exhausted", 32'(exh), 0);

        // R2/R4: exhaustive 3-bit triples, each held one cycle, standbys hostile
        slot[3] = 8'hFF; slot[4] = 8'h00;
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                for (int c = 0; c < 8; c++) begin
                    step();
                    slot[0] = 8'(a * 37); slot[1] = 8'(b * 37); slot[2] = 8'(c * 37);
                    #5;
                    chk("R2 majority", 32'(voted), 32'(maj3(slot[0], slot[1], slot[2])));
                    step();
                    slot[0] = 8'h5A; slot[1] = 8'h5A; slot[2] = 8'h5A;
                    #5;
                end
            end
        end
        chk("R4 no retire on short bursts", 32'(mask), 32'b00111);
        chk("R4 no fault pulse", 32'(fault), 0);

        // R4: disagree, agree, disagree on slot 2
        all_slots(8'h5A);
        step(); slot[2] = 8'h00; #5;
        step(); slot[2] = 8'h5A; #5;
        step(); slot[2] = 8'h00; #5;
        step(); slot[2] = 8'h5A; #5;
        chk("R4 restart count", 32'(mask), 32'b00111);

        // R5/R3: slot 1 fails persistently
        step(); slot[1] = 8'hA5; #5;
        chk("R3 masked first cycle", 32'(voted), 32'h5A);
        step(); #5;
        chk("R4 still active after 1", 32'(mask), 32'b00111);
        chk("R3 masked second cycle", 32'(voted), 32'h5A);
        step(); #5;
        chk("R5 swap to slot3", 32'(mask), 32'b01101);
        chk("R5 fault pulse", 32'(fault), 1);
        chk("R8 no multi", 32'(multi), 0);
        chk("R3 masked at swap", 32'(voted), 32'h5A);
        chk("R7 not yet exhausted", 32'(exh), 0);
        step(); slot[1] = 8'h00; #5;
        chk("R5 fault one cycle", 32'(fault), 0);
        chk("R2 retired slot ignored", 32'(voted), 32'h5A);

        // R6/R7: slot 0 fails, slot 4 joins, standbys used up
        step(); slot[0] = 8'h11; #5;
        step(); #5;
        step(); #5;
        chk("R6 ascending standby", 32'(mask), 32'b11100);
        chk("R7 exhausted raised", 32'(exh), 1);
        chk("R5 fault second swap", 32'(fault), 1);

        // R7: slot 3 fails with no standby left
        step(); slot[3] = 8'h22; #5;
        step(); #5;
        step(); #5;
        chk("R7 dropped", 32'(mask), 32'b10100);
        chk("R7 fault on drop", 32'(fault), 1);
        chk("R7 exhausted sticky", 32'(exh), 1);
        chk("R3 masked at drop", 32'(voted), 32'h5A);

        // R2: tie between two active slots gives 0
        step(); slot[2] = 8'hF0; slot[4] = 8'h3C; #5;
        chk("R2 tie", 32'(voted), 32'h30);
        step(); slot[2] = 8'h5A; slot[4] = 8'h5A; #5;
        chk("R4 tie burst no retire", 32'(mask), 32'b10100);
        chk("R9 count stable", 32'($countones(mask)), 2);

        // R8: three primaries all disagree with the vote
        step();
        slot[0] = 8'h01; slot[1] = 8'h02; slot[2] = 8'h04; slot[3] = 8'h00; slot[4] = 8'h00;
        do_reset();
        #5;
        chk("R1 mask after reset", 32'(mask), 32'b00111);
        chk("R1 exhausted cleared", 32'(exh), 0);
        chk("R2 no majority", 32'(voted), 0);
        step(); #5;
        chk("R8 none before K", 32'(mask), 32'b00111);
        step(); #5;
        chk("R8 lowest first", 32'(mask), 32'b01110);
        chk("R8 multi pulse", 32'(multi), 1);
        chk("R8 fault with multi", 32'(fault), 1);
        step(); #5;
        chk("R8 next lowest", 32'(mask), 32'b11100);
        chk("R8 multi again", 32'(multi), 1);
        chk("R7 exhausted", 32'(exh), 1);
        step(); #5;
        chk("R8 last dropped", 32'(mask), 32'b11000);
        chk("R8 single fault", 32'(multi), 0);
        chk("R5 fault on drop", 32'(fault), 1);
        step(); #5;
        chk("R5 fault cleared", 32'(fault), 0);
        chk("R9 stable", 32'(mask), 32'b11000);
        chk("R2 result", 32'(voted), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule